// File: doc/BRIEF.md
# Ripple-Carry Arithmetic and Logic Unit

This block is a purely combinational integer unit for a load/store processor datapath. The operand width is a parameter. One bit cell is repeated across that width. Each cell holds a full adder, a switch that passes B or its complement, and a small result selector. The carries ripple from bit 0 to the top bit.

A 4-bit operation code chooses the function. The operand-invert input applies the logic functions against the complement of B. The unsigned flag silences overflow for add and subtract. The zero flag is used for equality tests, which run as a subtract and then a zero check.

The carry out of the top bit is exported so that unsigned comparisons can be observed.

Top module: `rc_alu`

## Requirements
- R1: With `inv_b`=0, codes 0000, 0001, 0010 and 0011 give A AND B, A OR B, A XOR B and NOR(A,B), bit by bit.
- R2: With `inv_b`=1, the same four codes use ~B in place of B.
- R3: Code 0100 gives A+B modulo 2^W. `cout` is the carry out of bit W-1 of A+B.
- R4: Code 0101 gives A+~B+1, which is A-B modulo 2^W. `cout` is 1 exactly when A>=B as unsigned values. `inv_b` has no effect on codes 0100 to 0111.
- R5: Code 0110 puts bit W-1 of A-B on result bit 0. All higher result bits are 0.
- R6: Code 0111 gives result 1 when A<B as unsigned values, and 0 otherwise. This is the complement of the subtract carry out.
- R7: `zero` is 1 exactly when every result bit is 0. Under code 0101 this means A equals B.
- R8: For codes 0100 and 0101 with `uns`=0, `ovf` is the carry into bit W-1 XOR the carry out of bit W-1. It is 1 only when both effective addends share a sign and the sum's sign differs from it. With `uns`=1, `ovf` is 0.
- R9: `ovf` is 0 for every code other than 0100 and 0101.
- R10: Codes 1000 to 1111 give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | W | First operand |
| b | input | W | Second operand |
| op | input | 4 | Operation code |
| inv_b | input | 1 | Use ~B for the logic functions |
| uns | input | 1 | Unsigned add/subtract; overflow is suppressed |
| y | output | W | Result |
| zero | output | 1 | High when the result is all zeros |
| ovf | output | 1 | Signed overflow |
| cout | output | 1 | Carry out of the top adder bit |

## Verification
Random operand pairs are applied with every operation code and every combination of the invert and unsigned inputs. These random pairs show whether each result-selector leg and the B complement are wired correctly.

Directed pairs cover equal operands, which drive the zero flag, and the most-positive and most-negative words. Those extreme words separate a true overflow from a sign change that is only expected. They also separate the signed less-than from the unsigned one.

The all-ones and zero operands exercise the longest carry ripple and the borrow boundary of the carry out.

// File: rtl/rc_alu.sv
module rc_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  input  logic         inv_b,
  input  logic         uns,
  output logic [W-1:0] y,
  output logic         zero,
  output logic         ovf,
  output logic         cout
);
  localparam int MSB = W - 1;

  logic arith, is_sub, flip, set_lt, c_msb_in;
  logic [W-1:0] sum;

  assign arith  = (op[3:2] == 2'b01);
  assign is_sub = arith && (op[1:0] != 2'b00);
  assign flip   = is_sub || (!op[3] && !op[2] && inv_b);

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_cell
      logic ci, co, bx, s, lt_in;
      if (i == 0) begin : g_lsb
        assign ci    = is_sub;
        assign lt_in = set_lt;
      end else begin : g_up
        assign ci    = g_cell[i-1].co;
        assign lt_in = 1'b0;
      end
      assign bx = b[i] ^ flip;
      assign s  = a[i] ^ bx ^ ci;
      assign co = (a[i] & bx) | (a[i] & ci) | (bx & ci);
      assign sum[i] = s;
      always_comb begin
        unique case (op)
          4'd0:    y[i] = a[i] & bx;
          4'd1:    y[i] = a[i] | bx;
          4'd2:    y[i] = a[i] ^ bx;
          4'd3:    y[i] = ~(a[i] | bx);
          4'd4,
          4'd5:    y[i] = s;
          4'd6,
          4'd7:    y[i] = lt_in;
          default: y[i] = 1'b0;
        endcase
      end
    end
  endgenerate

  assign c_msb_in = g_cell[MSB].ci;
  assign cout     = g_cell[MSB].co;
  assign set_lt   = op[0] ? ~cout : sum[MSB];
  assign zero     = ~|y;
  assign ovf      = arith && !op[1] && !uns && (c_msb_in ^ cout);
endmodule

module rc_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [3:0]   op,
  input logic         inv_b,
  input logic         uns,
  input logic [W-1:0] y,
  input logic         zero,
  input logic         ovf,
  input logic         cout
);
  always_comb begin
    if (!$isunknown({a, b, op, inv_b, uns, y, zero, ovf, cout})) begin
      if (op == 4'd5)
        p_sub_value_r4: assert (y == W'(a - b)) else $error("R4 subtract value");
      if (op == 4'd6)
        p_slt_upper_zero_r5: assert (y[W-1:1] == '0) else $error("R5 upper bits");
      if (op == 4'd5)
        p_eq_zero_r7: assert (zero == (a == b)) else $error("R7 equality");
      if (op == 4'd4 && ovf)
        p_ovf_signs_r8: assert (a[W-1] == b[W-1] && y[W-1] != a[W-1]) else $error("R8 ovf signs");
      if (uns)
        p_no_overflow_r8: assert (!ovf) else $error("R8 unsigned ovf");
      if (op != 4'd4 && op != 4'd5)
        p_ovf_only_arith_r9: assert (!ovf) else $error("R9 ovf");
      if (op[3])
        p_hi_codes_zero_r10: assert (y == '0) else $error("R10 result");
    end
  end
endmodule

bind rc_alu rc_alu_chk #(.W(W)) u_chk (.*);

// File: tb/rc_alu_tb.sv
module rc_alu_tb_top;
  localparam int W = 32;
  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic [W-1:0] a, b, y;
  logic [3:0] op;
  logic inv_b, uns, zero, ovf, cout;
  int checks = 0, errors = 0;
  bit done = 0;

  rc_alu #(.W(W)) dut_i (.a(a), .b(b), .op(op), .inv_b(inv_b), .uns(uns),
                         .y(y), .zero(zero), .ovf(ovf), .cout(cout));

  function automatic logic [W-1:0] eb(input logic [3:0] o, input logic [W-1:0] bv, input logic iv);
    if (o == 4'd5 || o == 4'd6 || o == 4'd7) return ~bv;
    if (o <= 4'd3 && iv) return ~bv;
    return bv;
  endfunction

  function automatic logic [W:0] ex_sum(input logic [3:0] o, input logic [W-1:0] av, input logic [W-1:0] bv, input logic iv);
    logic cin;
    cin = (o >= 4'd5 && o <= 4'd7);
    return {1'b0, av} + {1'b0, eb(o, bv, iv)} + (W+1)'(cin);
  endfunction

  function automatic logic [W-1:0] ex_y(input logic [3:0] o, input logic [W-1:0] av, input logic [W-1:0] bv, input logic iv);
    logic [W-1:0] bx;
    logic [W:0] s;
    bx = eb(o, bv, iv);
    s = ex_sum(o, av, bv, iv);
    case (o)
      4'd0: return av & bx;
      4'd1: return av | bx;
      4'd2: return av ^ bx;
      4'd3: return ~(av | bx);
      4'd4, 4'd5: return s[W-1:0];
      4'd6: return W'(s[W-1]);
      4'd7: return W'(av < bv);
      default: return '0;
    endcase
  endfunction

  function automatic logic ex_ovf(input logic [3:0] o, input logic [W-1:0] av, input logic [W-1:0] bv, input logic un);
    logic [W-1:0] bx;
    logic [W:0] s;
    if (!(o == 4'd4 || o == 4'd5) || un) return 1'b0;
    bx = eb(o, bv, 1'b0);
    s = ex_sum(o, av, bv, 1'b0);
    return (av[W-1] == bx[W-1]) && (s[W-1] != av[W-1]);
  endfunction

  function automatic string rtag(input logic [3:0] o, input logic iv);
    if (o <= 4'd3) return iv ? "R2" : "R1";
    case (o)
      4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h: got %h expected %h", req, op, a, b, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [W-1:0] av, input logic [W-1:0] bv, input logic iv, input logic un);
    logic [W-1:0] ey;
    logic [W:0] s;
    @(negedge clk);
    op = o; a = av; b = bv; inv_b = iv; uns = un;
    #1;
    ey = ex_y(o, av, bv, iv);
    s = ex_sum(o, av, bv, iv);
    chk(rtag(o, iv), y, ey);
    chk("R7", W'(zero), W'(ey == '0));
    chk((o == 4'd4 || o == 4'd5) ? "R8" : "R9", W'(ovf), W'(ex_ovf(o, av, bv, un)));
    if (o >= 4'd4 && o <= 4'd7) chk(o == 4'd4 ? "R3" : "R4", W'(cout), W'(s[W]));
  endtask

  initial begin
    op = 0; a = 0; b = 0; inv_b = 0; uns = 0;
    void'($urandom(32'd20250607));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R7", W'(zero), W'(1'b1));
    chk("R1", y, '0);
    apply(4'd5, 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b0);
    apply(4'd5, 32'h1234_5678, 32'h1234_5678, 1'b1, 1'b0);
    apply(4'd4, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0);
    apply(4'd4, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b1);
    apply(4'd4, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0);
    apply(4'd5, 32'h8000_0000, 32'h0000_0001, 1'b0, 1'b0);
    apply(4'd5, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b0);
    apply(4'd4, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b1);
    apply(4'd6, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0);
    apply(4'd7, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0);
    apply(4'd6, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 1'b0);
    apply(4'd7, 32'h0000_0003, 32'h0000_0003, 1'b0, 1'b0);
    apply(4'd3, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0);
    apply(4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
    for (int k = 0; k < 3000; k++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom;
      rb = ($urandom_range(0, 7) == 0) ? ra : W'($urandom);
      apply(4'($urandom_range(0, 15)), ra, rb, 1'($urandom), 1'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule